// File: doc/BRIEF.md
# Extended Golay Systematic Encoder

This block turns a 12-bit message into a 24-bit codeword of the extended binary Golay code (length 24, dimension 12, minimum distance 8, rate one half). The message occupies the upper half of the codeword. The lower half holds the parity: 11 bits are the remainder of a serial polynomial division by the cyclic generator, and one bit is an overall even-parity bit. In the forward direction the codeword is built one bit per clock. Over 24 clock periods the datapath shifts in the message, then flushes the remainder, then appends the parity bit.

The code is self-dual, so its 12x12 parity matrix P satisfies P·Pᵀ = I. Because of this the same hardware also works in reverse. When it is given the 12 parity bits p, it rebuilds the message as d = p·Pᵀ. The remainder register steps through the successive powers of x modulo the generator, which produces the rows of P one per cycle, and one message bit is formed per cycle. A request is taken on `start` only while the block is idle. `done` pulses when the result is final.

Top module: `golay_enc`

## Requirements
- R1: After reset, `busy` and `done` are 0, and `code_out` and `data_out` are all zero.
- R2: In forward mode (`mode`=0), `code_out` at `done` is laid out as follows:
  - `code_out[23:12]` equals `din`.
  - `code_out[11:1]` is the remainder of x^11·m(x) divided by g(x) = x^11+x^9+x^7+x^6+x^5+x+1, where m(x) = Σ din[i]·x^i. Remainder bit j is at `code_out[1+j]`.
  - `code_out[0]` makes the XOR of all 24 bits zero.
- R3: Every forward codeword has Hamming weight 0, 8, 12, 16 or 24.
- R4: In reverse mode (`mode`=1), with `din` set to the parity half `code_out[11:0]` of the forward codeword of message m, `data_out` at `done` equals m.
- R5: `done` is sampled high exactly 24 rising edges after the edge that accepts a forward start, and exactly 12 edges after the edge that accepts a reverse start. `busy` is 1 from the cycle after acceptance until `done`, and 0 when `done` is high.
- R6: `done` is high for exactly one cycle per accepted start.
- R7: A `start` raised while `busy` is 1 is ignored, whatever `mode` and `din` it carries. The running operation finishes with its original result and timing.
- R8: A forward run does not alter `data_out`, and a reverse run does not alter `code_out`. Each output keeps its last result until a later run of its own mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request; accepted only when `busy` is 0 |
| mode | input | 1 | 0 forward (message to codeword), 1 reverse (parity to message) |
| din | input | 12 | Message bits (forward) or parity half (reverse), captured on acceptance |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse; result final |
| code_out | output | 24 | Forward codeword {message, remainder, overall parity} |
| data_out | output | 12 | Message rebuilt in reverse mode |

## Verification
The bench encodes all 4096 messages and compares each codeword with a long division computed in the bench. A wrong generator tap or a reversed shift order would corrupt the remainder field. The bench also checks the weight of every codeword, which catches a misplaced or inverted overall parity bit even when the division itself is correct. Each parity half is then fed back through reverse mode to recover its message. A row generator stepping from the wrong power of x, or a wrong mask for the parity-bit column, would return a different message for most inputs. Further directed cases cover the following:
- a start raised mid-run, which a design without the busy guard would let restart the operation with the wrong data;
- the exact `done` cycle and its single-cycle width, which an off-by-one counter would shift or stretch;
- each output holding its value across the other mode.

// File: rtl/golay_pkg.sv
package golay_pkg;

  typedef enum logic {
    ENC_FWD = 1'b0,
    ENC_REV = 1'b1
  } enc_mode_e;

  // Per-cycle action issued by the sequencer to the datapath.
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_DIV   = 3'd1,  // forward: shift a message bit through the divider
    OP_FLUSH = 3'd2,  // forward: move the remainder out, top bit first
    OP_TAIL  = 3'd3,  // forward: append the overall parity bit
    OP_POW   = 3'd4   // reverse: emit one message bit, step to the next power of x
  } step_op_e;

endpackage

// File: rtl/golay_ctrl.sv
module golay_ctrl
  import golay_pkg::*;
#(
  parameter int K = 12
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  enc_mode_e mode_in,
  output logic      busy,
  output logic      done,
  output logic      load,
  output step_op_e  op
);

  localparam int N    = 2 * K;
  localparam int CNTW = $clog2(N);
  localparam logic [CNTW-1:0] LAST_FWD = CNTW'(N - 1);
  localparam logic [CNTW-1:0] LAST_REV = CNTW'(K - 1);
  localparam logic [CNTW-1:0] DIV_END  = CNTW'(K);

  logic [CNTW-1:0] cnt_q;
  enc_mode_e       mode_q;
  logic            busy_q;
  logic            done_q;
  logic            last_step;

  assign load      = start && !busy_q;
  assign last_step = busy_q && (cnt_q == ((mode_q == ENC_REV) ? LAST_REV : LAST_FWD));

  always_comb begin
    if (!busy_q)                op = OP_IDLE;
    else if (mode_q == ENC_REV) op = OP_POW;
    else if (cnt_q < DIV_END)   op = OP_DIV;
    else if (cnt_q == LAST_FWD) op = OP_TAIL;
    else                        op = OP_FLUSH;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      mode_q <= ENC_FWD;
    end else begin
      done_q <= last_step;
      if (load) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        mode_q <= mode_in;
      end else if (last_step) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy_q && $past(busy_q)));

  // R5
  run_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_step) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_step) |=> $stable(mode_q));

endmodule

// File: rtl/golay_divider.sv
module golay_divider
  import golay_pkg::*;
#(
  parameter int              DEG   = 11,
  parameter logic [DEG-1:0]  GPOLY = 'h2E3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  enc_mode_e      load_mode,
  input  step_op_e       op,
  input  logic           din_bit,
  output logic [DEG-1:0] rem
);

  // Multiply the residue by x and reduce modulo g(x).
  function automatic logic [DEG-1:0] mul_x(logic [DEG-1:0] s);
    return {s[DEG-2:0], 1'b0} ^ (s[DEG-1] ? GPOLY : '0);
  endfunction

  // One step of the serial division, message bit entering at the top.
  function automatic logic [DEG-1:0] div_in(logic [DEG-1:0] s, logic b);
    return {s[DEG-2:0], 1'b0} ^ ((b ^ s[DEG-1]) ? GPOLY : '0);
  endfunction

  logic [DEG-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (load) begin
      // Reverse mode starts from x^DEG mod g(x), which equals the low taps.
      rem_q <= (load_mode == ENC_REV) ? GPOLY : '0;
    end else begin
      case (op)
        OP_DIV:   rem_q <= div_in(rem_q, din_bit);
        OP_FLUSH: rem_q <= {rem_q[DEG-2:0], 1'b0};
        OP_POW:   rem_q <= mul_x(rem_q);
        default:  rem_q <= rem_q;
      endcase
    end
  end

  assign rem = rem_q;

  // R2
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_TAIL) |-> (rem_q == '0));

  // R4
  pow_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POW) |-> (rem_q != '0));

endmodule

// File: rtl/golay_collect.sv
module golay_collect
  import golay_pkg::*;
#(
  parameter int K   = 12,
  parameter int DEG = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [K-1:0]   din,
  input  step_op_e       op,
  input  logic [DEG-1:0] rem,
  output logic           msg_bit,
  output logic [2*K-1:0] code_out,
  output logic [K-1:0]   data_out
);

  localparam int N = 2 * K;

  // Row of the parity matrix for the current power: remainder bits, then the
  // bit that gives the unit message's codeword even weight.
  function automatic logic rev_bit(logic [K-1:0] p, logic [DEG-1:0] t);
    return ^(p & {t, ~^t});
  endfunction

  logic [K-1:0] in_q;
  logic [N-1:0] cw_q;
  logic [K-1:0] dr_q;
  logic         acc_q;

  assign msg_bit = in_q[K-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      cw_q  <= '0;
      dr_q  <= '0;
      acc_q <= 1'b0;
    end else if (load) begin
      in_q  <= din;
      acc_q <= 1'b0;
    end else begin
      case (op)
        OP_DIV: begin
          in_q  <= {in_q[K-2:0], 1'b0};
          cw_q  <= {cw_q[N-2:0], in_q[K-1]};
          acc_q <= acc_q ^ in_q[K-1];
        end
        OP_FLUSH: begin
          cw_q  <= {cw_q[N-2:0], rem[DEG-1]};
          acc_q <= acc_q ^ rem[DEG-1];
        end
        OP_TAIL: cw_q <= {cw_q[N-2:0], acc_q};
        OP_POW:  dr_q <= {rev_bit(in_q, rem), dr_q[K-1:1]};
        default: ;
      endcase
    end
  end

  assign code_out = cw_q;
  assign data_out = dr_q;

  // R2
  tail_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_TAIL) |=> (^cw_q == 1'b0));

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_POW) |=> $stable(dr_q));

  // R8
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POW || op == OP_IDLE) |=> $stable(cw_q));

endmodule

// File: rtl/golay_enc.sv
module golay_enc
  import golay_pkg::*;
#(
  parameter int               K     = 12,
  parameter logic [K-2:0]     GPOLY = 'h2E3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode,
  input  logic [K-1:0]     din,
  output logic             busy,
  output logic             done,
  output logic [2*K-1:0]   code_out,
  output logic [K-1:0]     data_out
);

  localparam int DEG = K - 1;

  logic           load;
  step_op_e       op;
  logic [DEG-1:0] rem;
  logic           msg_bit;
  enc_mode_e      mode_e;

  assign mode_e = enc_mode_e'(mode);

  golay_ctrl #(.K(K)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mode_in (mode_e),
    .busy    (busy),
    .done    (done),
    .load    (load),
    .op      (op)
  );

  golay_divider #(.DEG(DEG), .GPOLY(GPOLY)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_mode (mode_e),
    .op        (op),
    .din_bit   (msg_bit),
    .rem       (rem)
  );

  golay_collect #(.K(K), .DEG(DEG)) u_col (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .din      (din),
    .op       (op),
    .rem      (rem),
    .msg_bit  (msg_bit),
    .code_out (code_out),
    .data_out (data_out)
  );

  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> (busy || done));

endmodule

// File: tb/sim_golay_enc.sv
module sim_golay_enc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [11:0] din = '0;
  logic        busy, done;
  logic [23:0] code_out;
  logic [11:0] data_out;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  int lat;

  always #2 clk = ~clk;

  golay_enc u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .din(din),
    .busy(busy), .done(done), .code_out(code_out), .data_out(data_out)
  );

  // Reference: long division of x^11*m(x) by the full 12-term generator.
  function automatic logic [10:0] ref_rem(logic [11:0] m);
    logic [22:0] v;
    v = {m, 11'b0};
    for (int i = 22; i >= 11; i--)
      if (v[i]) v = v ^ (23'h000AE3 << (i - 11));
    return v[10:0];
  endfunction

  function automatic logic [23:0] ref_cw(logic [11:0] m);
    logic [10:0] r;
    r = ref_rem(m);
    return {m, r, ^{m, r}};
  endfunction

  task automatic check(input bit ok, input string req, input logic [23:0] act,
                       input logic [23:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; drives start now, returns at the negedge where done is seen.
  task automatic run_op(input logic md, input logic [11:0] d);
    start = 1'b1; mode = md; din = d;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R5 watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [23:0] cw;
    logic [23:0] prev_cw;
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0, "R1 flags", {22'b0, busy, done}, 24'h0);
    check(code_out == 0 && data_out == 0, "R1 outputs", code_out ^ {12'b0, data_out}, 24'h0);

    // R7: start raised mid-run with other mode and data must be ignored
    start = 1'b1; mode = 1'b0; din = 12'hA5C;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    repeat (4) begin @(negedge clk); lat++; end
    start = 1'b1; mode = 1'b1; din = 12'h3F0;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done) begin @(negedge clk); lat++; end
    check(code_out == ref_cw(12'hA5C), "R7 result", code_out, ref_cw(12'hA5C));
    check(lat == 24, "R7 timing", 24'(lat), 24'd24);
    @(negedge clk);
    check(!done && !busy, "R7 no restart", {22'b0, busy, done}, 24'h0);

    // R8: reverse leaves code_out, forward leaves data_out
    run_op(1'b1, ref_cw(12'h123) & 24'hFFF);
    check(data_out == 12'h123, "R4 directed", {12'b0, data_out}, 24'h123);
    check(code_out == ref_cw(12'hA5C), "R8 code held", code_out, ref_cw(12'hA5C));
    @(negedge clk);
    run_op(1'b0, 12'h800);
    check(data_out == 12'h123, "R8 data held", {12'b0, data_out}, 24'h123);
    repeat (3) @(negedge clk);
    check(code_out == ref_cw(12'h800), "R8 idle hold", code_out, ref_cw(12'h800));

    // Exhaustive sweep, back to back
    prev_cw = code_out;
    for (int m = 0; m < 4096; m++) begin
      run_op(1'b0, 12'(m));
      cw = ref_cw(12'(m));
      check(code_out == cw, "R2 codeword", code_out, cw);
      w = $countones(code_out);
      check(w == 0 || w == 8 || w == 12 || w == 16 || w == 24, "R3 weight",
            24'(w), 24'd8);
      check(lat == 24 && !busy, "R5 forward latency", 24'(lat), 24'd24);
      if (m < 16) begin
        @(negedge clk);
        check(!done, "R6 forward pulse", {23'b0, done}, 24'h0);
      end
      run_op(1'b1, cw[11:0]);
      check(data_out == 12'(m), "R4 round trip", {12'b0, data_out}, 24'(m));
      check(lat == 12 && !busy, "R5 reverse latency", 24'(lat), 24'd12);
      check(code_out == cw, "R8 code after reverse", code_out, cw);
      if (m < 16) begin
        @(negedge clk);
        check(!done, "R6 reverse pulse", {23'b0, done}, 24'h0);
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule